// File: doc/BRIEF.md
# Interrupt Request Flag Register

An 8-bit register that records pending interrupt events. Two timer overflow pulses and four external interrupt pins each have one sticky flag. A pin can raise its flag only while its function-enable input is high. It raises the flag on the edge chosen by its edge-select input, after the pin has passed through a two-flop synchronizer.

Software reads the register through a synchronous port. It clears a flag by writing 0 to that bit. Writing 1 has no effect, so software cannot set a flag. Accepting an interrupt does not clear its flag. Two reserved bits read as fixed constants and ignore writes. Each flag also drives a request line, gated by an external enable bit.

Bit layout as read:
- Bit 7: first timer overflow.
- Bit 6: second timer overflow.
- Bit 5: reserved, reads 0.
- Bit 4: reserved, reads 1.
- Bits 3 to 0: pins 3 to 0.

Top module: `irq_flag_reg`

## Requirements
- R1: After reset `rd_data` is 0x10 and `req_out` is 0.
- R2: A one-cycle pulse on `ovf_a` sets bit 7, visible at the next clock edge.
- R3: A one-cycle pulse on `ovf_b` sets bit 6, visible at the next clock edge.
- R4: Bit 5 always reads 0 and bit 4 always reads 1, whatever is written to them.
- R5: Pin n sets bit n on the third clock edge after the pin changes. With `pin_rise[n]`=1 a rising edge sets the flag; with 0 a falling edge sets it. The opposite edge does not set the flag.
- R6: While `pin_fn_en[n]` is 0, edges on pin n do not set bit n.
- R7: A write with bit k = 0 clears flag k. A write with bit k = 1 leaves flag k unchanged and cannot set it.
- R8: A flag stays set until software clears it. No other input clears it.
- R9: If a set event and a write-0 clear reach the same flag in the same cycle, the flag ends at 1.
- R10: `req_out[5]` is bit 7 AND `req_en[5]`. `req_out[4]` is bit 6 AND `req_en[4]`. `req_out[3:0]` is bits 3:0 AND `req_en[3:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data; a 0 bit clears the flag at that position |
| rd_data | output | 8 | Register contents as read |
| ovf_a | input | 1 | First timer overflow pulse (sets bit 7) |
| ovf_b | input | 1 | Second timer overflow pulse (sets bit 6) |
| pin_in | input | 4 | Asynchronous interrupt pins |
| pin_fn_en | input | 4 | Per-pin interrupt function enable |
| pin_rise | input | 4 | Per-pin edge select: 1 = rising, 0 = falling |
| req_en | input | 6 | Request enables {bit7, bit6, bits3..0} |
| req_out | output | 6 | Gated requests {bit7, bit6, bits3..0} |

## Verification
The embedded assertions check four properties on every cycle:
- Without a set event, no flag rises, so writes cannot set flags.
- Without a write, no flag falls.
- A timer pulse always leaves its flag set, even against a simultaneous clear.
- An uncontested write of 0 clears the first timer flag.

Only the bench scenarios can show the following:
- The three-edge pin latency.
- That the opposite edge does not set a flag.
- That a disabled pin is ignored.
- The reset value and the request gating.

// File: rtl/irq_flag_reg.sv
module irq_flag_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       ovf_a,
  input  logic       ovf_b,
  input  logic [3:0] pin_in,
  input  logic [3:0] pin_fn_en,
  input  logic [3:0] pin_rise,
  input  logic [5:0] req_en,
  output logic [5:0] req_out
);

  logic [3:0] sync1, sync2, sync3;
  logic [3:0] pin_hit;
  logic [5:0] flags, set_v, clr_v;
  logic       unused_rsv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      sync3 <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
      sync3 <= sync2;
    end
  end

  assign pin_hit = pin_fn_en & ((pin_rise & sync2 & ~sync3) |
                                (~pin_rise & ~sync2 & sync3));

  assign set_v = {ovf_a, ovf_b, pin_hit};
  assign clr_v = wr_en ? ~{wr_data[7:6], wr_data[3:0]} : 6'b0;
  assign unused_rsv = ^wr_data[5:4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_v) | set_v;
  end

  assign rd_data = {flags[5:4], 2'b01, flags[3:0]};
  assign req_out = flags & req_en;

  // R7
  no_false_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_v == 6'b0) |=> ((flags & ~$past(flags)) == 6'b0));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((~flags & $past(flags)) == 6'b0));

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_a |=> rd_data[7]);

  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[7] && !ovf_a) |=> !rd_data[7]);

endmodule

// File: tb/irq_flag_reg_test.sv
module irq_flag_reg_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       wr_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic       ovf_a = 0, ovf_b = 0;
  logic [3:0] pin_in = 0, pin_fn_en = 4'hF, pin_rise = 4'hF;
  logic [5:0] req_en = 0;
  logic [5:0] req_out;
  int checks = 0, fails = 0;
  bit done = 0;

  irq_flag_reg uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // {wr_en, wr_data, ovf_a, ovf_b, expected rd_data}
  localparam logic [18:0] VEC [8] = '{
    {1'b0, 8'h00, 1'b1, 1'b0, 8'h90},  // R2
    {1'b0, 8'h00, 1'b0, 1'b1, 8'hD0},  // R3
    {1'b1, 8'hFF, 1'b0, 1'b0, 8'hD0},  // R7 write 1 no effect
    {1'b1, 8'h7F, 1'b0, 1'b0, 8'h50},  // R7 clear bit 7
    {1'b1, 8'h00, 1'b1, 1'b0, 8'h90},  // R9 set wins
    {1'b1, 8'h2F, 1'b0, 1'b0, 8'h10},  // R4 reserved ignore
    {1'b0, 8'h00, 1'b0, 1'b1, 8'h50},  // R3 again
    {1'b0, 8'h00, 1'b0, 1'b0, 8'h50}   // R8 hold
  };

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    wait_cycles(3);
    rst_n = 1;
    wait_cycles(1);
    check8("R1 rd_data", rd_data, 8'h10);
    check8("R1 req_out", {2'b0, req_out}, 8'h00);

    for (int i = 0; i < 8; i++) begin
      wr_en = VEC[i][18]; wr_data = VEC[i][17:10];
      ovf_a = VEC[i][9]; ovf_b = VEC[i][8];
      @(negedge clk);
      wr_en = 0; ovf_a = 0; ovf_b = 0;
      check8($sformatf("vec%0d R2/R3/R4/R7/R8/R9", i), rd_data, VEC[i][7:0]);
    end

    wr(8'h00);
    check8("R7 clear all", rd_data, 8'h10);

    // R5 rising edge on pin 0
    pin_in[0] = 1;
    wait_cycles(2);
    check8("R5 not yet after 2 edges", rd_data, 8'h10);
    wait_cycles(1);
    check8("R5 rising pin0", rd_data, 8'h11);

    // R5 falling select: rise ignored, fall sets
    pin_rise[1] = 0;
    pin_in[1] = 1;
    wait_cycles(4);
    check8("R5 opposite edge pin1", rd_data, 8'h11);
    pin_in[1] = 0;
    wait_cycles(3);
    check8("R5 falling pin1", rd_data, 8'h13);

    // R6 disabled pin 2
    pin_fn_en[2] = 0;
    pin_in[2] = 1;
    wait_cycles(4);
    pin_in[2] = 0;
    wait_cycles(4);
    check8("R6 disabled pin2", rd_data, 8'h13);

    // R5 pin 3 rising
    pin_in[3] = 1;
    wait_cycles(3);
    check8("R5 rising pin3", rd_data, 8'h1B);

    // R10 request gating
    ovf_a = 1;
    @(negedge clk);
    ovf_a = 0;
    req_en = 6'b101010;
    #1;
    check8("R10 req_out", {2'b0, req_out}, {2'b0, 6'b101010});
    req_en = 6'b010101;
    #1;
    check8("R10 req_out b", {2'b0, req_out}, {2'b0, 6'b000001});

    // R8 no auto clear while flags used
    wait_cycles(5);
    check8("R8 hold", rd_data, 8'h9B);

    // R1 reset again
    rst_n = 0;
    #1;
    check8("R1 async reset", rd_data, 8'h10);
    check8("R1 req_out reset", {2'b0, req_out}, 8'h00);

    done = 1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule